// File: doc/BRIEF.md
# Indexed Segmented Dot-Product Unit

This block computes a lane-indexed dot product over a vector whose length is set by a parameter given in bytes. The vector is split into 64-bit result lanes. Each lane adds four widened products to its own accumulator lane.

The first factor of each product comes from the lane's own four 16-bit elements in source A. The second factor does not come from the lane itself. It comes from a four-element group of source B that is shared by both lanes of a 128-bit segment, and a one-bit immediate picks which of the segment's two groups is used. Every segment reads its own groups, so lanes 4, 5, 8, 9 and all later lanes read data from their own segment.

A control input selects signed (two's complement) or unsigned arithmetic for the 16-bit elements. The result is registered and appears one cycle after an input strobe.

Top module: `idx_dot_unit`

## Requirements
- R1: Element j of a source vector is held in bits [16j+15:16j], and lane i of the accumulator and of the result is held in bits [64i+63:64i]. On each strobe, result lane i equals accumulator lane i plus the sum, over k = 0..3, of A element 4i+k multiplied by the selected B element.
- R2: The B elements for lane i come from the 128-bit segment that contains lane i. Both lanes of a segment use the same four B elements.
- R3: The selected B element has index 8*(i div 2) + 4*sel + k, where sel is the one-bit immediate `grp_sel`.
- R4: When `is_signed` is 1, every 16-bit element is sign-extended to 64 bits before it is multiplied.
- R5: When `is_signed` is 0, every 16-bit element is zero-extended to 64 bits before it is multiplied.
- R6: Accumulation wraps modulo 2^64. There is no saturation.
- R7: `out_valid` is 1 in the cycle after a cycle in which `in_valid` was 1, and 0 otherwise. The new result is visible in that same cycle.
- R8: While `in_valid` is 0, `result` keeps its value, whatever the data inputs do.
- R9: During and after reset, `out_valid` is 0 and `result` is all zeros until the first strobe.
- R10: Every lane is correct for vector lengths of 16, 32, 64, 128 and 256 bytes. The vector length must be a multiple of 16, and the lane count is the vector length divided by 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| is_signed | input | 1 | 1 = signed elements, 0 = unsigned elements |
| grp_sel | input | 1 | Picks the group of four B elements within each segment |
| acc_vec | input | VLEN_BYTES*8 | Accumulator vector, 64-bit lanes |
| src_a | input | VLEN_BYTES*8 | Source A, 16-bit elements |
| src_b | input | VLEN_BYTES*8 | Source B, 16-bit elements |
| out_valid | output | 1 | Result strobe |
| result | output | VLEN_BYTES*8 | Result vector, 64-bit lanes |

## Verification
Every result is due exactly one rising edge after the strobe that carried its operands. The bench drives operands on a falling edge and reads `result` and `out_valid` on the next falling edge, which is half a cycle after that rising edge. To check R8 and R7, the bench then lowers the strobe, changes all data inputs, and samples again after two more edges. At that point the previous result must still be held and `out_valid` must be low. Five instances, one for each supported vector length, receive the same stimulus, and each instance is compared lane by lane against a reference function in the bench.

// File: rtl/idx_dot_pkg.sv
`timescale 1ns/1ps
package idx_dot_pkg;
  localparam int ELEM_W    = 16;
  localparam int LANE_W    = 64;
  localparam int GRP_ELEMS = 4;
  localparam int SEG_LANES = 2;
  localparam int GRP_W     = ELEM_W * GRP_ELEMS;

  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [ELEM_W-1:0] elem_t;

  // Extend one 16-bit element to a 64-bit lane: sign-extend or zero-extend
  function automatic lane_t widen(input elem_t e, input logic sgn);
    return sgn ? {{(LANE_W-ELEM_W){e[ELEM_W-1]}}, e} : {{(LANE_W-ELEM_W){1'b0}}, e};
  endfunction

  // Product of two widened elements, truncated to 64 bits (wraps modulo 2^64)
  function automatic lane_t wide_mul(input elem_t x, input elem_t y, input logic sgn);
    lane_t p;
    p = widen(x, sgn) * widen(y, sgn);
    return p;
  endfunction
endpackage

// File: rtl/idx_group_pick.sv
`timescale 1ns/1ps
module idx_group_pick
  import idx_dot_pkg::*;
#(
  parameter int NELEM    = 32,
  parameter int LANE_IDX = 0
) (
  input  logic [NELEM*ELEM_W-1:0] src_b,
  input  logic                    sel,
  output logic [GRP_W-1:0]        grp
);
  // First element of this lane's segment
  localparam int SEG_FIRST = (LANE_IDX - (LANE_IDX % SEG_LANES)) * GRP_ELEMS;
  localparam int LO_BIT    = SEG_FIRST * ELEM_W;
  localparam int HI_BIT    = (SEG_FIRST + GRP_ELEMS) * ELEM_W;

  assign grp = sel ? src_b[HI_BIT +: GRP_W] : src_b[LO_BIT +: GRP_W];
endmodule

// File: rtl/idx_lane_mac.sv
`timescale 1ns/1ps
module idx_lane_mac
  import idx_dot_pkg::*;
(
  input  lane_t            acc,
  input  logic [GRP_W-1:0] a_grp,
  input  logic [GRP_W-1:0] b_grp,
  input  logic             sgn,
  output lane_t            sum
);
  lane_t prod [GRP_ELEMS];

  for (genvar k = 0; k < GRP_ELEMS; k++) begin : g_prod
    assign prod[k] = wide_mul(a_grp[k*ELEM_W +: ELEM_W], b_grp[k*ELEM_W +: ELEM_W], sgn);
  end

  always_comb begin
    sum = acc;
    for (int k = 0; k < GRP_ELEMS; k++) sum = sum + prod[k];
  end
endmodule

// File: rtl/idx_dot_unit.sv
`timescale 1ns/1ps
module idx_dot_unit
  import idx_dot_pkg::*;
#(
  parameter int VLEN_BYTES = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    is_signed,
  input  logic                    grp_sel,
  input  logic [VLEN_BYTES*8-1:0] acc_vec,
  input  logic [VLEN_BYTES*8-1:0] src_a,
  input  logic [VLEN_BYTES*8-1:0] src_b,
  output logic                    out_valid,
  output logic [VLEN_BYTES*8-1:0] result
);
  localparam int VBITS = VLEN_BYTES * 8;
  localparam int LANES = VBITS / LANE_W;
  localparam int NELEM = VBITS / ELEM_W;
  localparam int NSEG  = LANES / SEG_LANES;

  // Group of B elements picked by each lane, brought out for the assertions
  logic [GRP_W-1:0] lane_grp [LANES];
  lane_t            lane_sum [LANES];
  logic [VBITS-1:0] next_res;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    idx_group_pick #(.NELEM(NELEM), .LANE_IDX(i)) u_pick (
      .src_b (src_b),
      .sel   (grp_sel),
      .grp   (lane_grp[i])
    );
    idx_lane_mac u_mac (
      .acc   (acc_vec[i*LANE_W +: LANE_W]),
      .a_grp (src_a[i*GRP_W +: GRP_W]),
      .b_grp (lane_grp[i]),
      .sgn   (is_signed),
      .sum   (lane_sum[i])
    );
    assign next_res[i*LANE_W +: LANE_W] = lane_sum[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);
  // R7
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid);
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(result));
  // R1
  zero_a_passes_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && src_a == '0) |=> result == $past(acc_vec));

  for (genvar s = 0; s < NSEG; s++) begin : g_seg_chk
    // R2
    seg_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_grp[2*s] == lane_grp[2*s+1]);
  end
endmodule

// File: tb/test_idx_dot_unit.sv
`timescale 1ns/1ps
module test_idx_dot_unit;
  localparam int NV   = 5;
  localparam int MAXW = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic is_signed = 1'b0;
  logic grp_sel = 1'b0;
  logic [MAXW-1:0] acc_v = '0, a_v = '0, b_v = '0;
  logic [MAXW-1:0] res_all [NV];
  logic            ov_all  [NV];
  logic [MAXW-1:0] last_exp;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  for (genvar g = 0; g < NV; g++) begin : g_vl
    localparam int VB = 16 << g;
    logic [VB*8-1:0] r;
    logic            ov;
    idx_dot_unit #(.VLEN_BYTES(VB)) i_idx_dot_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_signed(is_signed),
      .grp_sel(grp_sel), .acc_vec(acc_v[VB*8-1:0]), .src_a(a_v[VB*8-1:0]),
      .src_b(b_v[VB*8-1:0]), .out_valid(ov), .result(r));
    assign res_all[g] = MAXW'(r);
    assign ov_all[g]  = ov;
  end

  // Reference for one lane: walk the segment by lane pairs
  function automatic logic [63:0] ref_lane(int i, logic [MAXW-1:0] acc, logic [MAXW-1:0] a,
                                           logic [MAXW-1:0] b, bit sel, bit sgn);
    logic [63:0] s;
    s = acc[64*i +: 64];
    for (int k = 0; k < 4; k++) begin
      logic [15:0] x, y;
      longint sx, sy;
      x = a[16*(4*i+k) +: 16];
      y = b[16*(8*(i/2) + 4*sel + k) +: 16];
      sx = sgn ? longint'($signed(x)) : longint'({48'b0, x});
      sy = sgn ? longint'($signed(y)) : longint'({48'b0, y});
      s = s + 64'(sx * sy);
    end
    return s;
  endfunction

  function automatic logic [MAXW-1:0] ref_vec(logic [MAXW-1:0] acc, logic [MAXW-1:0] a,
                                              logic [MAXW-1:0] b, bit sel, bit sgn);
    logic [MAXW-1:0] v;
    for (int i = 0; i < 32; i++) v[64*i +: 64] = ref_lane(i, acc, a, b, sel, sgn);
    return v;
  endfunction

  task automatic cmp_all(string tag, logic [MAXW-1:0] exp, bit exp_ov);
    for (int g = 0; g < NV; g++) begin
      int lanes = 2 << g;
      bit bad = 0;
      checks++;
      for (int i = 0; i < lanes; i++) begin
        if (res_all[g][64*i +: 64] !== exp[64*i +: 64]) begin
          if (!bad) $display("FAIL %s vlen=%0d lane %0d actual %h expected %h", tag, 16 << g, i,
                             res_all[g][64*i +: 64], exp[64*i +: 64]);
          bad = 1;
        end
      end
      if (ov_all[g] !== exp_ov) begin
        $display("FAIL %s/R7 vlen=%0d out_valid actual %b expected %b", tag, 16 << g, ov_all[g], exp_ov);
        bad = 1;
      end
      if (bad) fails++;
    end
  endtask

  task automatic apply(string tag, logic [MAXW-1:0] acc, logic [MAXW-1:0] a,
                       logic [MAXW-1:0] b, bit sel, bit sgn);
    @(negedge clk);
    acc_v = acc; a_v = a; b_v = b; grp_sel = sel; is_signed = sgn; in_valid = 1'b1;
    last_exp = ref_vec(acc, a, b, sel, sgn);
    @(negedge clk);
    in_valid = 1'b0;
    cmp_all(tag, last_exp, 1'b1);
  endtask

  function automatic logic [MAXW-1:0] rnd_vec();
    logic [MAXW-1:0] v;
    for (int w = 0; w < MAXW/32; w++) v[32*w +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [MAXW-1:0] fill16(logic [15:0] e);
    logic [MAXW-1:0] v;
    for (int j = 0; j < MAXW/16; j++) v[16*j +: 16] = e;
    return v;
  endfunction

  initial begin : watchdog
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [MAXW-1:0] ramp;
    void'($urandom(32'd1234));
    for (int j = 0; j < MAXW/16; j++) ramp[16*j +: 16] = 16'(j / 4);
    repeat (3) @(negedge clk);
    cmp_all("R9 in reset", '0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_all("R9 after reset", '0, 1'b0);

    // R10 R2: ramp of group numbers so each segment yields a distinct value
    apply("R10 ramp sel0", '0, fill16(16'd1), ramp, 1'b0, 1'b1);
    // R3: second group of each segment
    apply("R3 ramp sel1", '0, fill16(16'd1), ramp, 1'b1, 1'b0);
    // R4: signed extremes
    apply("R4 signed", rnd_vec(), fill16(16'h8000), fill16(16'h7fff), 1'b0, 1'b1);
    apply("R4 signed neg", '0, fill16(16'hffff), ramp, 1'b1, 1'b1);
    // R5: unsigned, all ones
    apply("R5 unsigned", '0, fill16(16'hffff), fill16(16'hffff), 1'b0, 1'b0);
    apply("R5 unsigned 8000", '0, fill16(16'h8000), fill16(16'h7fff), 1'b1, 1'b0);
    // R6: wrap past 2^64
    apply("R6 wrap", {MAXW{1'b1}}, fill16(16'd1), fill16(16'd1), 1'b0, 1'b0);
    // R1: zero A passes the accumulator through
    apply("R1 zero a", rnd_vec(), '0, rnd_vec(), 1'b1, 1'b1);

    // R8: changing inputs without a strobe leaves result unchanged
    @(negedge clk);
    acc_v = rnd_vec(); a_v = rnd_vec(); b_v = rnd_vec(); grp_sel = ~grp_sel; is_signed = ~is_signed;
    @(negedge clk);
    cmp_all("R8 hold", last_exp, 1'b0);

    for (int n = 0; n < 40; n++)
      apply("R1 random", rnd_vec(), rnd_vec(), rnd_vec(), 1'($urandom), 1'($urandom));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule